// File: doc/BRIEF.md
# Unique-ID Address Resolver

This block sits in every node on a shared open-drain line and lets the node win a bus address by bitwise arbitration on its unique identifier. The bus controller opens a resolution round with a one-cycle start pulse and then clocks bit slots with a strobe. During the identifier slots, each node that has no address yet puts its identifier on the line, most significant bit first. It pulls the line low for a 0 and releases it for a 1. A low line overrides a released one. A node that releases the line but reads back low has lost, and it stays silent until the round ends.

After the identifier slots, the controller drives the address on the line. The one node still contending captures it and raises its assigned flag. Every other node keeps following the slot count so that it can take part again at the next start pulse. A node that holds an address no longer drives the line. If a round's identifier slots pass with the line never pulled low, no node is left without an address, and every node reports that resolution is complete.

Top module: `uid_addr_resolver`

## Requirements
- R1: After reset, assigned_o is 0, node_addr_o is 0, resolve_done_o is 0 and line_drive_low_o is 0.
- R2: A round_start_i pulse makes an unassigned node contend. In identifier slot k (k = 0 for the first bit_tick_i after the pulse), a contending node drives line_drive_low_o = 1 exactly when uid_i bit (UID_W-1-k) is 0. The line is sampled on each bit_tick_i cycle.
- R3: A contending node that releases the line in a slot but samples line_i = 0 stops driving for the rest of the round.
- R4: The contending node that remains after UID_W slots samples line_i in the next ADDR_W slots as the address, most significant bit first, with a high line read as 1. It then sets assigned_o = 1 and node_addr_o to that value. With distinct identifiers, the lowest identifier wins.
- R5: A node that lost does not change assigned_o or node_addr_o, and it contends again in the next round.
- R6: An assigned node never drives the line, and its address stays fixed until reset.
- R7: If line_i is never 0 during a round's UID_W identifier slots, resolve_done_o becomes 1 at the last slot, no address phase follows, and the flag clears at the next round_start_i. The all-ones identifier is reserved.
- R8: bit_tick_i pulses outside a round change nothing.
- R9: A round_start_i pulse inside a round restarts the round at slot 0 and takes priority over a bit_tick_i in the same cycle.
- R10: No node drives the line during the address slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| round_start_i | input | 1 | One-cycle pulse that opens a resolution round |
| bit_tick_i | input | 1 | Bit-slot strobe; line sampled in this cycle |
| uid_i | input | UID_W | Unique identifier of this node |
| line_i | input | 1 | Sampled level of the shared line |
| line_drive_low_o | output | 1 | 1 pulls the shared line low |
| assigned_o | output | 1 | Node holds an address |
| node_addr_o | output | ADDR_W | Captured address |
| resolve_done_o | output | 1 | Last round saw no contender |

## Verification
A wrong slot counter or bit select shows up on line_drive_low_o in the very slot it goes wrong, because the level driven no longer matches the identifier bit. A loser that fails to drop out pulls the line low in a later identifier slot, and with several nodes on the wired line this also corrupts the outcome for the others. A wrong contention or assignment state becomes visible one cycle after the last address slot, through assigned_o and node_addr_o on every node. A wrong completion flag shows one cycle after the last identifier slot.

// File: rtl/ares_pkg.sv
package ares_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ID   = 2'd1,
        PH_ADDR = 2'd2
    } phase_t;
endpackage

// File: rtl/ares_uid_bit_sel.sv
module ares_uid_bit_sel #(
    parameter int UID_W = 32,
    parameter int CNT_W = 6
) (
    input  logic [UID_W-1:0] uid_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             bit_o
);
    // slot k carries identifier bit UID_W-1-k (MSB first)
    always_comb begin
        bit_o = 1'b1;
        for (int i = 0; i < UID_W; i++) begin
            if (cnt_i == CNT_W'(i)) bit_o = uid_i[UID_W-1-i];
        end
    end
endmodule

// File: rtl/ares_addr_shift.sv
module ares_addr_shift #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              latch_en_i,
    input  logic              bit_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] sr;
        logic [ADDR_W-1:0] addr;
    } sh_t;

    sh_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (shift_en_i) st_d.sr = {st_q.sr[ADDR_W-2:0], bit_i};
        if (latch_en_i) st_d.addr = {st_q.sr[ADDR_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;

    // R6: the captured address changes only on a latch strobe
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en_i |=> $stable(addr_o));
endmodule

// File: rtl/ares_round_ctrl.sv
module ares_round_ctrl
    import ares_pkg::*;
#(
    parameter int UID_W  = 32,
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             round_start_i,
    input  logic             bit_tick_i,
    input  logic             line_i,
    input  logic             my_bit_i,
    output phase_t           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             contend_o,
    output logic             assigned_o,
    output logic             done_o,
    output logic             shift_en_o,
    output logic             latch_en_o
);
    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
        logic             contend;
        logic             saw_zero;
        logic             done;
        logic             assigned;
    } st_t;

    st_t  st_q, st_d;
    logic saw_now;

    always_comb begin
        st_d       = st_q;
        shift_en_o = 1'b0;
        latch_en_o = 1'b0;
        saw_now    = st_q.saw_zero | ~line_i;
        if (round_start_i) begin
            st_d.phase    = PH_ID;
            st_d.cnt      = '0;
            st_d.contend  = ~st_q.assigned;
            st_d.saw_zero = 1'b0;
            st_d.done     = 1'b0;
        end else if (bit_tick_i) begin
            unique case (st_q.phase)
                PH_ID: begin
                    st_d.saw_zero = saw_now;
                    if (st_q.contend && my_bit_i && !line_i) st_d.contend = 1'b0;
                    if (st_q.cnt == CNT_W'(UID_W-1)) begin
                        st_d.cnt = '0;
                        if (saw_now) begin
                            st_d.phase = PH_ADDR;
                        end else begin
                            st_d.phase = PH_IDLE;
                            st_d.done  = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    shift_en_o = 1'b1;
                    if (st_q.cnt == CNT_W'(ADDR_W-1)) begin
                        st_d.phase = PH_IDLE;
                        st_d.cnt   = '0;
                        if (st_q.contend) begin
                            latch_en_o    = 1'b1;
                            st_d.assigned = 1'b1;
                            st_d.contend  = 1'b0;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign phase_o    = st_q.phase;
    assign cnt_o      = st_q.cnt;
    assign contend_o  = st_q.contend;
    assign assigned_o = st_q.assigned;
    assign done_o     = st_q.done;

    // R6: an address, once held, is kept until reset
    p_assigned_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.assigned |=> st_q.assigned);
    // R3: a loser stays out for the rest of the round
    p_loser_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ID && !st_q.contend && !round_start_i) |=> !st_q.contend);
    // R2: slot counter stays inside the identifier
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ID) |-> (st_q.cnt < CNT_W'(UID_W)));
    // R7: completion appears only as the round closes without an address phase
    p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> (st_q.phase == PH_IDLE) && $stable(st_q.assigned));
endmodule

// File: rtl/uid_addr_resolver.sv
module uid_addr_resolver
    import ares_pkg::*;
#(
    parameter int UID_W  = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              round_start_i,
    input  logic              bit_tick_i,
    input  logic [UID_W-1:0]  uid_i,
    input  logic              line_i,
    output logic              line_drive_low_o,
    output logic              assigned_o,
    output logic [ADDR_W-1:0] node_addr_o,
    output logic              resolve_done_o
);
    localparam int MAX_LEN = (UID_W > ADDR_W) ? UID_W : ADDR_W;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    phase_t           phase_w;
    logic [CNT_W-1:0] cnt_w;
    logic             contend_w, my_bit_w, shift_en_w, latch_en_w;

    ares_uid_bit_sel #(.UID_W(UID_W), .CNT_W(CNT_W)) u_sel (
        .uid_i (uid_i),
        .cnt_i (cnt_w),
        .bit_o (my_bit_w)
    );

    ares_round_ctrl #(.UID_W(UID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .round_start_i (round_start_i),
        .bit_tick_i    (bit_tick_i),
        .line_i        (line_i),
        .my_bit_i      (my_bit_w),
        .phase_o       (phase_w),
        .cnt_o         (cnt_w),
        .contend_o     (contend_w),
        .assigned_o    (assigned_o),
        .done_o        (resolve_done_o),
        .shift_en_o    (shift_en_w),
        .latch_en_o    (latch_en_w)
    );

    ares_addr_shift #(.ADDR_W(ADDR_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en_w),
        .latch_en_i (latch_en_w),
        .bit_i      (line_i),
        .addr_o     (node_addr_o)
    );

    assign line_drive_low_o = (phase_w == PH_ID) && contend_w && !my_bit_w;

    // R6: an assigned node keeps the line released
    p_assigned_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        assigned_o |-> !line_drive_low_o);
    // R10: address slots are left to the controller
    p_addr_slot_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_w == PH_ADDR) |-> !line_drive_low_o);
endmodule

// File: tb/tb_uid_addr_resolver.sv
module tb_uid_addr_resolver;
    localparam int CLK_P  = 10;
    localparam int UID_W  = 8;
    localparam int ADDR_W = 7;
    localparam int SLOTS  = UID_W + ADDR_W;
    localparam logic [UID_W-1:0] UIDS [3] = '{8'hA5, 8'h3C, 8'h3D};
    // {done expected, winner (3 = none), address offered}
    localparam logic [9:0] VEC [4] = '{
        {1'b0, 2'd1, 7'h11},
        {1'b0, 2'd2, 7'h22},
        {1'b0, 2'd0, 7'h33},
        {1'b1, 2'd3, 7'h55}
    };

    logic clk = 0, rst_n = 0, rs = 0, tick = 0, ctrl_low = 0, line;
    logic [2:0] drv, asg, dn;
    logic [ADDR_W-1:0] adr [3];
    logic drv_log [3][SLOTS];
    logic exp_asg [3];
    logic [ADDR_W-1:0] exp_adr [3];
    int n_chk = 0, n_err = 0;

    always #(CLK_P/2) clk = ~clk;
    assign line = ~(|drv | ctrl_low);

    for (genvar g = 0; g < 3; g++) begin : g_node
        if (g == 0) begin : g_a
            uid_addr_resolver #(.UID_W(UID_W), .ADDR_W(ADDR_W)) dut (
                .clk(clk), .rst_n(rst_n), .round_start_i(rs), .bit_tick_i(tick),
                .uid_i(UIDS[g]), .line_i(line), .line_drive_low_o(drv[g]),
                .assigned_o(asg[g]), .node_addr_o(adr[g]), .resolve_done_o(dn[g]));
        end else begin : g_o
            uid_addr_resolver #(.UID_W(UID_W), .ADDR_W(ADDR_W)) dut_peer (
                .clk(clk), .rst_n(rst_n), .round_start_i(rs), .bit_tick_i(tick),
                .uid_i(UIDS[g]), .line_i(line), .line_drive_low_o(drv[g]),
                .assigned_o(asg[g]), .node_addr_o(adr[g]), .resolve_done_o(dn[g]));
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_round(input logic [ADDR_W-1:0] a);
        @(negedge clk) rs = 1;
        @(negedge clk) rs = 0;
        for (int k = 0; k < SLOTS; k++) begin
            ctrl_low = (k >= UID_W) ? ~a[ADDR_W-1-(k-UID_W)] : 1'b0;
            tick = 1;
            #1;
            for (int n = 0; n < 3; n++) drv_log[n][k] = drv[n];
            @(negedge clk);
        end
        tick = 0; ctrl_low = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int n = 0; n < 3; n++) begin exp_asg[n] = 0; exp_adr[n] = '0; end
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 assigned", 32'(asg), 0);
        chk("R1 addr", 32'(adr[1]), 0);
        chk("R1 done", 32'(dn), 0);
        chk("R1 drive", 32'(drv), 0);
        @(negedge clk) rst_n = 1;

        // R8 ticks outside a round do nothing
        tick = 1;
        repeat (4) @(negedge clk);
        tick = 0;
        #1;
        chk("R8 drive idle", 32'(drv), 0);
        chk("R8 assigned idle", 32'(asg), 0);
        chk("R8 done idle", 32'(dn), 0);

        // R9 restart inside a round, start wins over same-cycle tick
        @(negedge clk) rs = 1;
        @(negedge clk) rs = 0; tick = 1;
        repeat (3) @(negedge clk);
        rs = 1;
        @(negedge clk) rs = 0; tick = 0;
        #1;
        chk("R9 restart slot0 B drives", 32'(drv[1]), 1);
        chk("R9 restart A rejoined, msb=1", 32'(drv[0]), 0);

        // table-driven rounds
        for (int v = 0; v < 4; v++) begin
            logic [ADDR_W-1:0] a;
            int w;
            a = VEC[v][6:0];
            w = int'(VEC[v][8:7]);
            run_round(a);
            if (w < 3) begin exp_asg[w] = 1; exp_adr[w] = a; end
            for (int n = 0; n < 3; n++) begin
                chk(n == w ? "R4 winner assigned" : "R5/R6 others assigned", 32'(asg[n]), 32'(exp_asg[n]));
                chk(n == w ? "R4 winner address" : "R5/R6 others address", 32'(adr[n]), 32'(exp_adr[n]));
                chk("R7 done flag", 32'(dn[n]), 32'(VEC[v][9]));
            end
            for (int k = UID_W; k < SLOTS; k++)
                for (int n = 0; n < 3; n++)
                    if (drv_log[n][k] !== 1'b0) chk("R10 released in address slot", 32'(drv_log[n][k]), 0);
            if (v == 0) begin
                chk("R2 slot0 B drives its 0", 32'(drv_log[1][0]), 1);
                chk("R2 slot0 A releases its 1", 32'(drv_log[0][0]), 0);
                chk("R2 slot2 C releases its 1", 32'(drv_log[2][2]), 0);
                chk("R2 slot7 B drives its 0", 32'(drv_log[1][7]), 1);
                chk("R3 A silent in slot1 after loss", 32'(drv_log[0][1]), 0);
                chk("R3 A silent in slot6 after loss", 32'(drv_log[0][6]), 0);
            end
            if (v == 1) begin
                chk("R6 assigned B silent slot0", 32'(drv_log[1][0]), 0);
                chk("R6 assigned B silent slot7", 32'(drv_log[1][7]), 0);
                chk("R5 loser C retries slot0", 32'(drv_log[2][0]), 1);
            end
        end

        // R7 flag clears on the next start
        @(negedge clk) rs = 1;
        @(negedge clk) rs = 0;
        #1;
        chk("R7 done cleared by start", 32'(dn), 0);
        chk("R6 assigned nodes silent", 32'(drv), 0);

        // R1 reset clears assignment
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        #1;
        chk("R1 reset clears assigned", 32'(asg), 0);
        chk("R1 reset clears address", 32'(adr[0]), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule